// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Width Converter

This block links a 36-bit long-word datapath to two narrow 18-bit ports. Its transmit half takes whole long words on a valid/ready handshake and hands them out as a series of narrow pieces. The receive half collects narrow pieces from a write port and presents each finished long word on its own valid/ready handshake. Each piece is either an 18-bit half-word or a 9-bit byte.

Piece width and piece order are set once, on the first clock edge after master reset is released. The order is big-endian or little-endian. Big-endian means the most significant piece moves first in both directions. Little-endian means the least significant piece moves first.

A synchronous partial reset drops any long word that is half split or half assembled. It keeps the captured settings. The block sits beside a FIFO that supplies and absorbs the long words. It runs on one clock.

Top module: `bus_match_conv`

## Requirements
- R1: While master reset is low, and on the first clock edge after it goes high, both `tx_wide_ready` and `rx_nar_ready` are 0. That edge captures `cfg_big_end` (1 = big-endian, 0 = little-endian) and `cfg_byte_mode` (1 = 9-bit pieces, 0 = 18-bit pieces). Both readies may be 1 from the next cycle on.
- R2: In big-endian unpacking, the first piece presented is the most significant one. The rest follow in falling significance. In 18-bit mode the first piece is bits 35:18 and the second is 17:0. In 9-bit mode the pieces are 35:27, 26:18, 17:9 and 8:0.
- R3: In little-endian unpacking, the least significant piece is presented first. The rest follow in rising significance. The same bit slices are used as in R2.
- R4: In 9-bit mode, a long word takes four narrow transfers. Bits 17:9 of `tx_nar_data` are 0. Bits 17:9 of `rx_nar_data` are ignored.
- R5: In big-endian packing, the first piece written lands in the most significant slice of the assembled word. Each later piece lands in the next lower slice.
- R6: In little-endian packing, the first piece written lands in the least significant slice. Each later piece lands in the next higher slice.
- R7: The unpacker accepts a new long word only after the last piece of the previous word has been accepted. While `tx_nar_valid` is high and `tx_nar_ready` is low, `tx_nar_data` holds its value.
- R8: The packer raises `rx_wide_valid` only after every piece of a word has arrived. While that word waits it keeps `rx_wide_data` steady and holds `rx_nar_ready` low.
- R9: When `soft_rst_n` is low on a clock edge, both in-flight words are cleared and both piece counters return to zero. The captured width and order are kept.
- R10: Once captured, width and order do not follow later changes of `cfg_big_end` or `cfg_byte_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, asynchronous assert, active low |
| soft_rst_n | input | 1 | Partial reset, synchronous, active low |
| cfg_big_end | input | 1 | Order select, captured at master reset release |
| cfg_byte_mode | input | 1 | Width select (1 = 9-bit), captured at master reset release |
| tx_wide_data | input | 36 | Long word to split |
| tx_wide_valid | input | 1 | Long word offered |
| tx_wide_ready | output | 1 | Unpacker can take a long word |
| tx_nar_data | output | 18 | Outgoing narrow piece |
| tx_nar_valid | output | 1 | Narrow piece offered |
| tx_nar_ready | input | 1 | Narrow reader takes the piece |
| rx_nar_data | input | 18 | Incoming narrow piece |
| rx_nar_valid | input | 1 | Narrow piece offered |
| rx_nar_ready | output | 1 | Packer can take a piece |
| rx_wide_data | output | 36 | Assembled long word |
| rx_wide_valid | output | 1 | Assembled word offered |
| rx_wide_ready | input | 1 | Consumer takes the assembled word |

## Verification
The bench uses the default lane width of 9 bits, which gives the 36-bit long word and the 18-bit narrow ports. It applies master reset four times, once for each combination of order and width. After each capture it flips the selection pins, so every later transfer also shows that the settings stay frozen.

With this build, all four piece slots and both half-word slots are reached in both directions. A partial reset is applied in the middle of a word in 9-bit mode.

// File: rtl/bmc_pkg.sv
`timescale 1ns/1ps
package bmc_pkg;

    typedef struct packed {
        logic big;
        logic byte_mode;
    } bmc_cfg_t;

    // Slot of the long word that piece number cnt occupies; slot 0 is least significant.
    function automatic logic [1:0] slot_of(input logic [1:0] cnt,
                                           input logic [1:0] last,
                                           input logic       big);
        return big ? (last - cnt) : cnt;
    endfunction

endpackage

// File: rtl/bmc_cfg.sv
`timescale 1ns/1ps
module bmc_cfg
    import bmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      big_in,
    input  logic      byte_in,
    output bmc_cfg_t  cfg,
    output logic      cfg_ok
);

    typedef struct packed {
        logic     armed;
        bmc_cfg_t sel;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.armed) begin
            st_d.armed         = 1'b1;
            st_d.sel.big       = big_in;
            st_d.sel.byte_mode = byte_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg    = st_q.sel;
    assign cfg_ok = st_q.armed;

endmodule

// File: rtl/bmc_unpack.sv
`timescale 1ns/1ps
module bmc_unpack
    import bmc_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  bmc_cfg_t              cfg,
    input  logic                  cfg_ok,
    input  logic [4*LANE_W-1:0]   wide_data,
    input  logic                  wide_valid,
    output logic                  wide_ready,
    output logic [2*LANE_W-1:0]   nar_data,
    output logic                  nar_valid,
    input  logic                  nar_ready
);

    localparam int HALF_W = 2 * LANE_W;
    localparam int WIDE_W = 4 * LANE_W;

    typedef struct packed {
        logic [WIDE_W-1:0] hold;
        logic              full;
        logic [1:0]        cnt;
    } unpk_state_t;

    unpk_state_t st_d, st_q;
    logic [1:0]        last;
    logic [1:0]        slot;
    logic [LANE_W-1:0] lane;
    logic [HALF_W-1:0] half;

    always_comb begin
        last = cfg.byte_mode ? 2'd3 : 2'd1;
        slot = slot_of(st_q.cnt, last, cfg.big);

        lane = '0;
        for (int i = 0; i < 4; i++) begin
            if (slot == 2'(i)) lane = st_q.hold[i*LANE_W +: LANE_W];
        end
        half = slot[0] ? st_q.hold[WIDE_W-1:HALF_W] : st_q.hold[HALF_W-1:0];

        nar_data   = cfg.byte_mode ? {{(HALF_W-LANE_W){1'b0}}, lane} : half;
        nar_valid  = st_q.full;
        wide_ready = cfg_ok && !st_q.full;

        st_d = st_q;
        if (wide_valid && wide_ready) begin
            st_d.hold = wide_data;
            st_d.full = 1'b1;
            st_d.cnt  = '0;
        end else if (nar_valid && nar_ready) begin
            if (st_q.cnt == last) begin
                st_d.full = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 2'd1;
            end
        end
        if (clr) begin
            st_d.full = 1'b0;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bmc_pack.sv
`timescale 1ns/1ps
module bmc_pack
    import bmc_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  bmc_cfg_t              cfg,
    input  logic                  cfg_ok,
    input  logic [2*LANE_W-1:0]   nar_data,
    input  logic                  nar_valid,
    output logic                  nar_ready,
    output logic [4*LANE_W-1:0]   wide_data,
    output logic                  wide_valid,
    input  logic                  wide_ready
);

    localparam int HALF_W = 2 * LANE_W;
    localparam int WIDE_W = 4 * LANE_W;

    typedef struct packed {
        logic [WIDE_W-1:0] acc;
        logic              done;
        logic [1:0]        cnt;
    } pk_state_t;

    pk_state_t  st_d, st_q;
    logic [1:0] last;
    logic [1:0] slot;

    always_comb begin
        last = cfg.byte_mode ? 2'd3 : 2'd1;
        slot = slot_of(st_q.cnt, last, cfg.big);

        nar_ready  = cfg_ok && !st_q.done;
        wide_valid = st_q.done;
        wide_data  = st_q.acc;

        st_d = st_q;
        if (nar_valid && nar_ready) begin
            if (cfg.byte_mode) begin
                for (int i = 0; i < 4; i++) begin
                    if (slot == 2'(i)) st_d.acc[i*LANE_W +: LANE_W] = nar_data[LANE_W-1:0];
                end
            end else begin
                for (int i = 0; i < 2; i++) begin
                    if (slot[0] == 1'(i)) st_d.acc[i*HALF_W +: HALF_W] = nar_data;
                end
            end
            if (st_q.cnt == last) begin
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 2'd1;
            end
        end else if (wide_valid && wide_ready) begin
            st_d.done = 1'b0;
        end
        if (clr) begin
            st_d.done = 1'b0;
            st_d.cnt  = '0;
            st_d.acc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bus_match_conv.sv
`timescale 1ns/1ps
module bus_match_conv
    import bmc_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst_n,
    input  logic                 cfg_big_end,
    input  logic                 cfg_byte_mode,
    input  logic [4*LANE_W-1:0]  tx_wide_data,
    input  logic                 tx_wide_valid,
    output logic                 tx_wide_ready,
    output logic [2*LANE_W-1:0]  tx_nar_data,
    output logic                 tx_nar_valid,
    input  logic                 tx_nar_ready,
    input  logic [2*LANE_W-1:0]  rx_nar_data,
    input  logic                 rx_nar_valid,
    output logic                 rx_nar_ready,
    output logic [4*LANE_W-1:0]  rx_wide_data,
    output logic                 rx_wide_valid,
    input  logic                 rx_wide_ready
);

    bmc_cfg_t cfg;
    logic     cfg_ok;
    logic     clr;

    assign clr = !soft_rst_n;

    bmc_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .big_in  (cfg_big_end),
        .byte_in (cfg_byte_mode),
        .cfg     (cfg),
        .cfg_ok  (cfg_ok)
    );

    bmc_unpack #(.LANE_W(LANE_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .cfg        (cfg),
        .cfg_ok     (cfg_ok),
        .wide_data  (tx_wide_data),
        .wide_valid (tx_wide_valid),
        .wide_ready (tx_wide_ready),
        .nar_data   (tx_nar_data),
        .nar_valid  (tx_nar_valid),
        .nar_ready  (tx_nar_ready)
    );

    bmc_pack #(.LANE_W(LANE_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .cfg        (cfg),
        .cfg_ok     (cfg_ok),
        .nar_data   (rx_nar_data),
        .nar_valid  (rx_nar_valid),
        .nar_ready  (rx_nar_ready),
        .wide_data  (rx_wide_data),
        .wide_valid (rx_wide_valid),
        .wide_ready (rx_wide_ready)
    );

endmodule

// File: rtl/bmc_checker.sv
`timescale 1ns/1ps
module bmc_checker
    import bmc_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst_n,
    input bmc_cfg_t             cfg,
    input logic                 cfg_ok,
    input logic                 tx_wide_valid,
    input logic                 tx_wide_ready,
    input logic [2*LANE_W-1:0]  tx_nar_data,
    input logic                 tx_nar_valid,
    input logic                 tx_nar_ready,
    input logic                 rx_nar_ready,
    input logic [4*LANE_W-1:0]  rx_wide_data,
    input logic                 rx_wide_valid,
    input logic                 rx_wide_ready
);

    AST_IDLE_UNTIL_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> (!tx_wide_ready && !rx_nar_ready));  // R1

    AST_CONFIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && $past(cfg_ok)) |-> $stable(cfg));  // R10

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_nar_valid && cfg.byte_mode) |-> (tx_nar_data[2*LANE_W-1:LANE_W] == '0));  // R4

    AST_TX_PIECE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_nar_valid && !tx_nar_ready && soft_rst_n) |=> (tx_nar_valid && $stable(tx_nar_data)));  // R7

    AST_TX_WORD_THEN_PIECES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wide_valid && tx_wide_ready && soft_rst_n) |=> (tx_nar_valid && !tx_wide_ready));  // R7

    AST_RX_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wide_valid && !rx_wide_ready && soft_rst_n) |=> (rx_wide_valid && $stable(rx_wide_data) && !rx_nar_ready));  // R8

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> (!tx_nar_valid && !rx_wide_valid));  // R9

    AST_SOFT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_n && cfg_ok) |=> (cfg_ok && $stable(cfg)));  // R9

endmodule

bind bus_match_conv bmc_checker #(.LANE_W(LANE_W)) u_bmc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst_n    (soft_rst_n),
    .cfg           (cfg),
    .cfg_ok        (cfg_ok),
    .tx_wide_valid (tx_wide_valid),
    .tx_wide_ready (tx_wide_ready),
    .tx_nar_data   (tx_nar_data),
    .tx_nar_valid  (tx_nar_valid),
    .tx_nar_ready  (tx_nar_ready),
    .rx_nar_ready  (rx_nar_ready),
    .rx_wide_data  (rx_wide_data),
    .rx_wide_valid (rx_wide_valid),
    .rx_wide_ready (rx_wide_ready)
);

// File: tb/bus_match_conv_bench.sv
`timescale 1ns/1ps
module bus_match_conv_bench;

    localparam int LANE_W = 9;
    localparam int HALF_W = 2 * LANE_W;
    localparam int WIDE_W = 4 * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              soft_rst_n = 1'b1;
    logic              cfg_big_end = 1'b0;
    logic              cfg_byte_mode = 1'b0;
    logic [WIDE_W-1:0] tx_wide_data = '0;
    logic              tx_wide_valid = 1'b0;
    logic              tx_wide_ready;
    logic [HALF_W-1:0] tx_nar_data;
    logic              tx_nar_valid;
    logic              tx_nar_ready = 1'b0;
    logic [HALF_W-1:0] rx_nar_data = '0;
    logic              rx_nar_valid = 1'b0;
    logic              rx_nar_ready;
    logic [WIDE_W-1:0] rx_wide_data;
    logic              rx_wide_valid;
    logic              rx_wide_ready = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  cur_big;
    bit  cur_byte;

    always #2 clk = ~clk;

    bus_match_conv #(.LANE_W(LANE_W)) u_bus_match_conv (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst_n    (soft_rst_n),
        .cfg_big_end   (cfg_big_end),
        .cfg_byte_mode (cfg_byte_mode),
        .tx_wide_data  (tx_wide_data),
        .tx_wide_valid (tx_wide_valid),
        .tx_wide_ready (tx_wide_ready),
        .tx_nar_data   (tx_nar_data),
        .tx_nar_valid  (tx_nar_valid),
        .tx_nar_ready  (tx_nar_ready),
        .rx_nar_data   (rx_nar_data),
        .rx_nar_valid  (rx_nar_valid),
        .rx_nar_ready  (rx_nar_ready),
        .rx_wide_data  (rx_wide_data),
        .rx_wide_valid (rx_wide_valid),
        .rx_wide_ready (rx_wide_ready)
    );

    task automatic check(input string tag, input logic [WIDE_W-1:0] got, input logic [WIDE_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int npieces();
        return cur_byte ? 4 : 2;
    endfunction

    // Piece k of a long word under the current order and width.
    function automatic logic [WIDE_W-1:0] piece(input logic [WIDE_W-1:0] w, input int k);
        int wd;
        int sh;
        wd = cur_byte ? LANE_W : HALF_W;
        sh = cur_big ? (npieces() - 1 - k) * wd : k * wd;
        return (w >> sh) & ((36'd1 << wd) - 36'd1);
    endfunction

    task automatic do_reset(input bit big, input bit byt);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_big_end = big;
        cfg_byte_mode = byt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 readies low in reset", {34'd0, tx_wide_ready, rx_nar_ready}, 36'd0);
        rst_n = 1'b1;
        check("R1 readies low before capture edge", {34'd0, tx_wide_ready, rx_nar_ready}, 36'd0);
        check("R1 outputs idle after reset", {34'd0, tx_nar_valid, rx_wide_valid}, 36'd0);
        @(negedge clk);
        check("R1 readies high after capture", {34'd0, tx_wide_ready, rx_nar_ready}, 36'd3);
        cur_big = big;
        cur_byte = byt;
        cfg_big_end = ~big;
        cfg_byte_mode = ~byt;
    endtask

    task automatic test_unpack(input logic [WIDE_W-1:0] w, input string ctx);
        string tag;
        tag = {cur_big ? "R2" : "R3", cur_byte ? " R4 " : " ", ctx};
        @(negedge clk);
        tx_nar_ready = 1'b0;
        check({"R7 idle unpacker ready ", ctx}, {35'd0, tx_wide_ready}, 36'd1);
        tx_wide_valid = 1'b1;
        tx_wide_data = w;
        @(posedge clk);
        @(negedge clk);
        tx_wide_valid = 1'b0;
        tx_wide_data = ~w;
        check({"R7 busy unpacker not ready ", ctx}, {35'd0, tx_wide_ready}, 36'd0);
        for (int k = 0; k < npieces(); k++) begin
            check({tag, " piece valid"}, {35'd0, tx_nar_valid}, 36'd1);
            check({tag, " piece data"}, {18'd0, tx_nar_data}, piece(w, k));
            if (k == 0) begin
                @(negedge clk);
                check({"R7 piece held under backpressure ", ctx}, {18'd0, tx_nar_data}, piece(w, k));
            end
            tx_nar_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tx_nar_ready = 1'b0;
            if (k < npieces() - 1)
                check({"R7 no new word mid split ", ctx}, {35'd0, tx_wide_ready}, 36'd0);
        end
        check({"R7 unpacker drained ", ctx}, {34'd0, tx_nar_valid, tx_wide_ready}, 36'd1);
    endtask

    task automatic test_pack(input logic [WIDE_W-1:0] w, input string ctx);
        string tag;
        tag = {cur_big ? "R5" : "R6", cur_byte ? " R4 " : " ", ctx};
        @(negedge clk);
        rx_wide_ready = 1'b0;
        for (int k = 0; k < npieces(); k++) begin
            check({"R8 packer ready for piece ", ctx}, {35'd0, rx_nar_ready}, 36'd1);
            rx_nar_valid = 1'b1;
            rx_nar_data = piece(w, k)[HALF_W-1:0];
            if (cur_byte) rx_nar_data[HALF_W-1:LANE_W] = 9'h1A5;
            @(posedge clk);
            @(negedge clk);
            rx_nar_valid = 1'b0;
            if (k < npieces() - 1)
                check({"R8 no word before last piece ", ctx}, {35'd0, rx_wide_valid}, 36'd0);
        end
        check({tag, " word valid"}, {35'd0, rx_wide_valid}, 36'd1);
        check({tag, " word data"}, rx_wide_data, w);
        check({"R8 no piece accepted while pending ", ctx}, {35'd0, rx_nar_ready}, 36'd0);
        @(negedge clk);
        check({"R8 word held ", ctx}, rx_wide_data, w);
        rx_wide_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_wide_ready = 1'b0;
        check({"R8 word consumed ", ctx}, {34'd0, rx_wide_valid, rx_nar_ready}, 36'd1);
    endtask

    task automatic test_partial_reset();
        @(negedge clk);
        tx_wide_valid = 1'b1;
        tx_wide_data = 36'h5_A5A5_A5A5;
        @(posedge clk);
        @(negedge clk);
        tx_wide_valid = 1'b0;
        tx_nar_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_nar_ready = 1'b0;
        for (int k = 0; k < 2; k++) begin
            rx_nar_valid = 1'b1;
            rx_nar_data = 18'h0_0077;
            @(posedge clk);
            @(negedge clk);
        end
        rx_nar_valid = 1'b0;
        soft_rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        soft_rst_n = 1'b1;
        check("R9 partial reset clears unpacker", {34'd0, tx_nar_valid, tx_wide_ready}, 36'd1);
        check("R9 partial reset clears packer", {34'd0, rx_wide_valid, rx_nar_ready}, 36'd1);
        test_unpack(36'hC_0123_4567, "R9 after partial reset");
        test_pack(36'h3_89AB_CDEF, "R9 after partial reset");
    endtask

    initial begin
        do_reset(1'b1, 1'b0);
        test_unpack(36'h9_1234_5678, "R10 big half");
        test_pack(36'h6_DEAD_BEEF, "R10 big half");
        do_reset(1'b0, 1'b0);
        test_unpack(36'hA_BCDE_F012, "R10 little half");
        test_pack(36'h1_0203_0405, "R10 little half");
        do_reset(1'b1, 1'b1);
        test_unpack(36'hF_0E1D_2C3B, "R10 big byte");
        test_pack(36'h8_4C2A_1937, "R10 big byte");
        do_reset(1'b0, 1'b1);
        test_unpack(36'h7_6543_210F, "R10 little byte");
        test_pack(36'h2_468A_CE13, "R10 little byte");
        test_partial_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule